// File: doc/BRIEF.md
# Temperature-Aware Supply Voltage Selector

This controller chooses one of a small set of discrete supply-voltage levels for logic that gets faster as the die warms up. The clock frequency stays fixed throughout. Only the voltage index changes. Level index 0 is the base voltage, which is the setting that is safe at the coldest corner. Each higher index is one step lower in voltage. A table holds one threshold temperature per index. A level may be used only once the die is at least as warm as that level's threshold. The controller takes a fresh signed die-temperature sample in whole degrees Celsius on every clock.

The controller has two modes. In tracking mode it picks the deepest level that is allowed at the present temperature, and it moves up or down as the temperature crosses threshold boundaries. In cycling mode it first holds a chosen mid level for a warm-up interval. It then drops to a chosen low level and stays there until the die cools to the low level's threshold. After that it returns to the mid level and repeats. This loop keeps the die near an optimum threshold. Both modes share the same safety rules. No level above the tracking choice is ever driven. A die at or past the programmed limit forces the base level. A disabled controller also outputs the base level, and the threshold table can be written only in that state.

All pins are plain control and status signals. The temperature input is a continuous sample taken on every clock, so it carries no valid/ready handshake and cannot apply back-pressure. Every output is registered: an input change shows up on the outputs after the next rising clock edge.

Top module: `thermal_vlevel_ctrl`

## Requirements
- R1: Out of reset, level_idx is 0, level_chg is 0 and over_limit is 0. Threshold entry 0 resets to -25 and every other entry resets to 127.
- R2: While enable is low, level_idx is 0. A table write (tbl_wr_en with tbl_wr_idx and tbl_wr_val) takes effect only while enable is low. A write attempted while enable is high leaves the table unchanged.
- R3: In tracking mode (mode_cycle=0), one cycle after a sample the level is the largest index i ≥ 1 whose threshold is ≤ the sample and < limit_temp. If no index qualifies, the level is 0.
- R4: Tracking follows boundary crossings in both directions. A falling temperature moves the level back toward 0 in the cycle after the crossing.
- R5: When temp_in ≥ limit_temp (signed), over_limit is 1 and level_idx is 0 from the next cycle. The cycling sequence is abandoned and restarts from warm-up once the die is below the limit again.
- R6: level_chg is 1 for exactly the cycles in which level_idx differs from its value in the previous cycle.
- R7: On entry to cycling mode, the mid level is output for W+1 cycles, where W = max(warm_cycles, settle_cycles). In the next cycle the low level is output, provided the tracking choice is at least low_sel. Otherwise the mid level is held until it is.
- R8: In the low phase, the low level is held while the sample stays above the low level's threshold. A sample ≤ that threshold returns the output to the mid level and restarts the full warm-up.
- R9: In cycling mode the output is never above the tracking choice for the same sample. The mid or low level is capped to that choice.
- R10: Clearing mode_cycle returns the output to the tracking choice in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller running; low forces the base level and opens the table |
| mode_cycle | input | 1 | 0 = tracking mode, 1 = warm-up/low cycling mode |
| temp_in | input | TW | Signed die temperature sample, °C |
| limit_temp | input | TW | Signed die temperature limit, °C |
| warm_cycles | input | CW | Programmed warm-up length in cycles |
| settle_cycles | input | CW | Regulator settling time, the minimum warm-up |
| mid_sel | input | IW | Index of the mid level used in cycling mode |
| low_sel | input | IW | Index of the low level used in cycling mode |
| tbl_wr_en | input | 1 | Threshold table write strobe |
| tbl_wr_idx | input | IW | Threshold table entry to write |
| tbl_wr_val | input | TW | Signed threshold value to write |
| level_idx | output | IW | Selected voltage level, 0 = base |
| level_chg | output | 1 | One-cycle pulse on each level change |
| over_limit | output | 1 | Die at or above the limit |

## Verification
On every cycle the assertions check the following. The level is forced to base while the controller is disabled or over the limit. The strobe matches the change in the level. The output never exceeds the tracking choice. In tracking mode the output equals that choice. The bench's scenarios are the only way to show the timed parts of the behaviour: the exact length of the warm-up, including the case where the settling time is longer than the programmed warm-up. They also show the hold of the low level down to its threshold, the restart of the loop, and that a table write made while the controller runs has no effect.

// File: rtl/tvs_pkg.sv
package tvs_pkg;
  typedef enum logic [1:0] {
    ST_TRACK = 2'd0,
    ST_WARM  = 2'd1,
    ST_LOW   = 2'd2
  } cyc_state_e;
endpackage

// File: rtl/tvs_thr_table.sv
module tvs_thr_table #(
  parameter int N       = 8,
  parameter int TW      = 8,
  parameter int IW      = 3,
  parameter int BASE_TH = -25
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_allow,
  input  logic                 wr_en,
  input  logic [IW-1:0]        wr_idx,
  input  logic signed [TW-1:0] wr_val,
  output logic [N*TW-1:0]      thr_flat
);
  localparam logic signed [TW-1:0] TOP_VAL  = {1'b0, {(TW-1){1'b1}}};
  localparam logic signed [TW-1:0] BASE_VAL = TW'(BASE_TH);

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic signed [TW-1:0] ent_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= (g == 0) ? BASE_VAL : TOP_VAL;
      end else if (wr_allow && wr_en && (wr_idx == IW'(g))) begin
        ent_q <= wr_val;
      end
    end
    assign thr_flat[g*TW +: TW] = ent_q;
  end
endmodule

// File: rtl/tvs_region_find.sv
module tvs_region_find #(
  parameter int N  = 8,
  parameter int TW = 8,
  parameter int IW = 3
) (
  input  logic [(N-1)*TW-1:0]  thr_upper,
  input  logic signed [TW-1:0] temp,
  input  logic signed [TW-1:0] limit,
  output logic [IW-1:0]        best_idx
);
  logic [N-1:0] elig;
  assign elig[0] = 1'b1;

  for (genvar g = 1; g < N; g++) begin : g_el
    logic signed [TW-1:0] th;
    assign th      = thr_upper[(g-1)*TW +: TW];
    assign elig[g] = (th <= temp) && (th < limit);
  end

  always_comb begin
    best_idx = '0;
    for (int i = 1; i < N; i++) begin
      if (elig[i]) best_idx = IW'(i);
    end
  end
endmodule

// File: rtl/tvs_cycle_fsm.sv
module tvs_cycle_fsm
  import tvs_pkg::*;
#(
  parameter int TW = 8,
  parameter int IW = 3,
  parameter int CW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic [IW-1:0]        direct_idx,
  input  logic signed [TW-1:0] temp,
  input  logic signed [TW-1:0] low_thr,
  input  logic [IW-1:0]        mid_sel,
  input  logic [IW-1:0]        low_sel,
  input  logic [CW-1:0]        warm_cycles,
  input  logic [CW-1:0]        settle_cycles,
  output logic [IW-1:0]        cyc_idx
);
  cyc_state_e  st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [CW-1:0] load_val;
  logic [IW-1:0] cand;

  assign load_val = (warm_cycles >= settle_cycles) ? warm_cycles : settle_cycles;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    if (!run) begin
      st_n  = ST_TRACK;
      cnt_n = '0;
    end else begin
      case (st_q)
        ST_TRACK: begin
          st_n  = ST_WARM;
          cnt_n = load_val;
        end
        ST_WARM: begin
          if (cnt_q != '0) cnt_n = cnt_q - 1'b1;
          else if (direct_idx >= low_sel) st_n = ST_LOW;
        end
        ST_LOW: begin
          if (temp <= low_thr) begin
            st_n  = ST_WARM;
            cnt_n = load_val;
          end
        end
        default: st_n = ST_TRACK;
      endcase
    end
  end

  always_comb begin
    case (st_n)
      ST_WARM: cand = mid_sel;
      ST_LOW:  cand = low_sel;
      default: cand = direct_idx;
    endcase
    cyc_idx = (cand > direct_idx) ? direct_idx : cand;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_TRACK;
      cnt_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
    end
  end
endmodule

// File: rtl/thermal_vlevel_ctrl.sv
module thermal_vlevel_ctrl #(
  parameter int N       = 8,
  parameter int TW      = 8,
  parameter int CW      = 16,
  parameter int BASE_TH = -25,
  localparam int IW     = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 mode_cycle,
  input  logic signed [TW-1:0] temp_in,
  input  logic signed [TW-1:0] limit_temp,
  input  logic [CW-1:0]        warm_cycles,
  input  logic [CW-1:0]        settle_cycles,
  input  logic [IW-1:0]        mid_sel,
  input  logic [IW-1:0]        low_sel,
  input  logic                 tbl_wr_en,
  input  logic [IW-1:0]        tbl_wr_idx,
  input  logic signed [TW-1:0] tbl_wr_val,
  output logic [IW-1:0]        level_idx,
  output logic                 level_chg,
  output logic                 over_limit
);
  logic [N*TW-1:0]      thr_flat;
  logic [IW-1:0]        direct_idx;
  logic [IW-1:0]        cyc_idx;
  logic [IW-1:0]        lvl_n;
  logic signed [TW-1:0] low_thr;
  logic                 over_c;
  logic                 run;

  tvs_thr_table #(.N(N), .TW(TW), .IW(IW), .BASE_TH(BASE_TH)) u_tbl (
    .clk(clk), .rst_n(rst_n), .wr_allow(!enable), .wr_en(tbl_wr_en),
    .wr_idx(tbl_wr_idx), .wr_val(tbl_wr_val), .thr_flat(thr_flat)
  );

  tvs_region_find #(.N(N), .TW(TW), .IW(IW)) u_find (
    .thr_upper(thr_flat[N*TW-1:TW]), .temp(temp_in), .limit(limit_temp),
    .best_idx(direct_idx)
  );

  always_comb begin
    low_thr = thr_flat[TW-1:0];
    for (int i = 1; i < N; i++) begin
      if (low_sel == IW'(i)) low_thr = thr_flat[i*TW +: TW];
    end
  end

  assign over_c = (temp_in >= limit_temp);
  assign run    = enable && mode_cycle && !over_c;

  tvs_cycle_fsm #(.TW(TW), .IW(IW), .CW(CW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .run(run), .direct_idx(direct_idx),
    .temp(temp_in), .low_thr(low_thr), .mid_sel(mid_sel), .low_sel(low_sel),
    .warm_cycles(warm_cycles), .settle_cycles(settle_cycles), .cyc_idx(cyc_idx)
  );

  always_comb begin
    if (!enable || over_c) lvl_n = '0;
    else                   lvl_n = cyc_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_idx  <= '0;
      level_chg  <= 1'b0;
      over_limit <= 1'b0;
    end else begin
      level_idx  <= lvl_n;
      level_chg  <= (lvl_n != level_idx);
      over_limit <= over_c;
    end
  end
endmodule

// File: rtl/tvs_chk.sv
module tvs_chk #(
  parameter int TW = 8,
  parameter int IW = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 enable,
  input logic                 mode_cycle,
  input logic signed [TW-1:0] temp_in,
  input logic signed [TW-1:0] limit_temp,
  input logic [IW-1:0]        direct_idx,
  input logic [IW-1:0]        level_idx,
  input logic                 level_chg,
  input logic                 over_limit
);
  p_disabled_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (level_idx == '0));

  p_track_direct_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !mode_cycle && (temp_in < limit_temp)) |=> (level_idx == $past(direct_idx)));

  p_over_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
    over_limit |-> (level_idx == '0));

  p_strobe_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (level_chg == (level_idx != $past(level_idx))));

  p_never_above_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (level_idx <= $past(direct_idx)));
endmodule

bind thermal_vlevel_ctrl tvs_chk #(.TW(TW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .mode_cycle(mode_cycle),
  .temp_in(temp_in), .limit_temp(limit_temp), .direct_idx(direct_idx),
  .level_idx(level_idx), .level_chg(level_chg), .over_limit(over_limit)
);

// File: tb/thermal_vlevel_ctrl_tb_top.sv
module thermal_vlevel_ctrl_tb_top;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              enable = 1'b0;
  logic              mode_cycle = 1'b0;
  logic signed [7:0] temp_in = 8'sd20;
  logic signed [7:0] limit_temp = 8'sd90;
  logic [15:0]       warm_cycles = 16'd5;
  logic [15:0]       settle_cycles = 16'd3;
  logic [2:0]        mid_sel = 3'd3;
  logic [2:0]        low_sel = 3'd4;
  logic              tbl_wr_en = 1'b0;
  logic [2:0]        tbl_wr_idx = '0;
  logic signed [7:0] tbl_wr_val = '0;
  logic [2:0]        level_idx;
  logic              level_chg;
  logic              over_limit;

  always #10 clk = ~clk;

  thermal_vlevel_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode_cycle(mode_cycle),
    .temp_in(temp_in), .limit_temp(limit_temp), .warm_cycles(warm_cycles),
    .settle_cycles(settle_cycles), .mid_sel(mid_sel), .low_sel(low_sel),
    .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_val(tbl_wr_val),
    .level_idx(level_idx), .level_chg(level_chg), .over_limit(over_limit)
  );

  // behavioural reference model
  int    m_thr [8];
  int    m_lvl, m_chg, m_over, m_st, m_cnt;
  int    n_checks = 0, n_fails = 0, n_cycles = 0;
  bit    started = 0;
  string cur_req = "R1";

  function automatic int mdir(int t, int lim);
    int d = 0;
    for (int i = 1; i < 8; i++)
      if (m_thr[i] <= t && m_thr[i] < lim) d = i;
    return d;
  endfunction

  always @(posedge clk) begin
    int t, lim, d, w, pick, nl;
    bit over, run;
    if (!rst_n) begin
      m_thr[0] = -25;
      for (int i = 1; i < 8; i++) m_thr[i] = 127;
      m_lvl = 0; m_chg = 0; m_over = 0; m_st = 0; m_cnt = 0;
    end else begin
      t = temp_in; lim = limit_temp;
      d = mdir(t, lim);
      over = (t >= lim);
      run = enable && mode_cycle && !over;
      w = (warm_cycles > settle_cycles) ? warm_cycles : settle_cycles;
      if (!run) m_st = 0;
      else if (m_st == 0) begin m_st = 1; m_cnt = w; end
      else if (m_st == 1) begin
        if (m_cnt > 0) m_cnt--;
        else if (d >= low_sel) m_st = 2;
      end else if (t <= m_thr[low_sel]) begin m_st = 1; m_cnt = w; end
      pick = (m_st == 1) ? mid_sel : (m_st == 2) ? low_sel : d;
      if (pick > d) pick = d;
      nl = (!enable || over) ? 0 : pick;
      m_chg = (nl != m_lvl);
      m_lvl = nl;
      m_over = over;
      if (!enable && tbl_wr_en) m_thr[tbl_wr_idx] = tbl_wr_val;
    end
    started = 1;
  end

  always @(negedge clk) begin
    if (started) begin
      n_checks++;
      if (level_idx !== 3'(m_lvl) || level_chg !== 1'(m_chg) || over_limit !== 1'(m_over)) begin
        n_fails++;
        $display("FAIL %s: lvl/chg/over actual %0d/%0d/%0d expected %0d/%0d/%0d",
                 cur_req, level_idx, level_chg, over_limit, m_lvl, m_chg, m_over);
      end
    end
  end

  always @(posedge clk) begin
    n_cycles++;
    if (n_cycles > 20000) begin
      n_fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", n_cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    // R1: reset state
    cur_req = "R1";
    step(4);
    rst_n = 1'b1;
    step(2);
    // R2: program table while disabled; level stays base
    cur_req = "R2";
    for (int i = 1; i < 8; i++) begin
      tbl_wr_en  = 1'b1;
      tbl_wr_idx = 3'(i);
      tbl_wr_val = (i == 1) ? 8'sd10 : (i == 2) ? 8'sd30 : (i == 3) ? 8'sd50 :
                   (i == 4) ? 8'sd70 : (i == 5) ? 8'sd95 : 8'sd127;
      temp_in    = 8'(i * 12);
      step(1);
    end
    tbl_wr_en = 1'b0;
    temp_in = 8'sd80;
    step(3);
    // R3: rising sweep in tracking mode; R5 at and over the limit
    enable = 1'b1;
    for (int t = -30; t <= 100; t += 5) begin
      cur_req = (t >= 90) ? "R5" : "R3";
      temp_in = 8'(t);
      step(2);
    end
    // R4 and R6: falling sweep, strobe on each crossing
    for (int t = 100; t >= -30; t -= 7) begin
      cur_req = (t % 2 == 0) ? "R4" : "R6";
      temp_in = 8'(t);
      step(2);
    end
    // R2: write while enabled is ignored (entry 3 would drop to -100)
    cur_req = "R2";
    temp_in = 8'sd35;
    tbl_wr_en = 1'b1; tbl_wr_idx = 3'd3; tbl_wr_val = -8'sd100;
    step(1);
    tbl_wr_en = 1'b0;
    step(3);
    // R7: warm-up of max(5,3) then low
    cur_req = "R7";
    temp_in = 8'sd80;
    mode_cycle = 1'b1;
    step(10);
    // R8: hold low above threshold, return at threshold, then hold mid when low unsafe
    cur_req = "R8";
    temp_in = 8'sd75;
    step(3);
    temp_in = 8'sd70;
    step(9);
    temp_in = 8'sd65;
    step(4);
    temp_in = 8'sd68;
    step(10);
    // R9: mid capped by tracking choice
    cur_req = "R9";
    temp_in = 8'sd40;
    step(4);
    temp_in = 8'sd5;
    step(3);
    // R10: leaving cycling mode
    cur_req = "R10";
    temp_in = 8'sd80;
    mode_cycle = 1'b0;
    step(3);
    // R7: settle time longer than the programmed warm-up
    cur_req = "R7";
    warm_cycles = 16'd1; settle_cycles = 16'd6;
    mode_cycle = 1'b1;
    step(10);
    // R5: over-limit during cycling, then restart from warm-up
    cur_req = "R5";
    temp_in = 8'sd95;
    step(3);
    temp_in = 8'sd80;
    step(10);
    // R2: disable while cycling
    cur_req = "R2";
    enable = 1'b0;
    step(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule